// File: doc/BRIEF.md
# Queued SPI Master

This block is an SPI bus master fed by a transmit queue. Each queue entry pairs a two-bit chip-select code with a data word. Software sets up the clock mode, frame length, bit order and divisor. It then programs an item count and pushes entries. The block pulls one entry per frame. For the length of that frame it asserts the chip-select line the entry names, shifts the word out on SO and samples SI into a receive FIFO. After the programmed number of frames it raises a one-cycle interrupt.

If the queue runs dry before the count is reached, the block waits with SCK idle and resumes when new entries arrive. Received words are read back in arrival order from a single data address. A clear command empties both FIFOs before a new run. In receive-only mode the written words serve only as placeholders and SO keeps its level.

The register bus has eight addresses:
- 0: control. Bit 0 powers the engine, bit 1 enables reception, bit 2 selects full duplex, bit 3 is CPOL, bit 4 is CPHA, bit 5 selects LSB first, and bits 11:8 hold the frame length.
- 1: SCK divisor.
- 2: item count.
- 3: chip-select polarity.
- 4: chip-select code.
- 5: transmit data push.
- 6: receive data pop.
- 7: status on read. On write, bit 0 clears both FIFOs.

Top module: `qspi_master`

## Requirements
- R1: After reset all four chip-select lines are high (inactive, active-low default), SCK and SO are low, irq is low, and the status word at address 7 reads 0x6. Status bit 0 is tx full, bit 1 tx empty, bit 2 rx empty and bit 3 busy.
- R2: A write to address 4 latches a chip-select code (bits 1:0), and a write to address 5 pushes that code with the 16-bit data word into a 16-entry queue. A push while status bit 0 (full) is set is dropped.
- R3: Writing address 2 with N (bits 3:0, 0 meaning 16) arms exactly N frames. Frames start only while control bit 0 (power) is 1. irq pulses high for exactly one cycle when the N-th frame completes.
- R4: SCK idles at control bit 3 (CPOL). Each SCK half period, including the delay from chip-select assertion to the first edge, lasts divisor+1 clock cycles, with the divisor at address 1. With control bit 4 (CPHA) at 0, data is sampled on leading edges and changed on trailing edges. With CPHA at 1 it is changed on leading edges and sampled on trailing edges.
- R5: Control bits 11:8 set the frame length: 1 to 15 bits, with 0 meaning 16. Control bit 5 at 0 sends and receives MSB first, and at 1 LSB first. Received words are right-aligned.
- R6: With control bit 2 at 1 (full duplex), SO carries each queued word. With it at 0 (receive only), SO holds its level for the whole run.
- R7: During each frame only the chip-select line named by its entry's code is active, at the level set by bit i of address 3 (1 = active high). All lines are inactive between frames.
- R8: Reads of address 6 return received words in arrival order and advance the FIFO. With control bit 1 (receive enable) at 0, received words are discarded and the receive FIFO stays empty.
- R9: When the queue is empty before the count is reached, SCK stays idle, no frame starts and irq stays low. The run continues once entries are pushed.
- R10: Writing address 7 with bit 0 set empties both FIFOs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops at address 6) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from address |
| irq | output | 1 | Run-complete pulse |
| sck | output | 1 | Serial clock |
| so | output | 1 | Serial data out |
| si | input | 1 | Serial data in |
| cs | output | 4 | Chip-select lines |

## Verification
Seeded random runs vary CPOL, CPHA, bit order, frame length, divisor, duplex, receive enable, chip-select polarity and item count. A bench slave drives SI from its own words and captures SO. Comparing both directions per frame separates bit-order, phase and length faults, and measuring every half period isolates divisor errors. Directed cases cover:
- A queue filled past capacity with power off, which exposes a dropped seventeenth push.
- A run starved halfway, which shows the idle wait rather than an abort.
- Reception disabled, and frames of 1 and 16 bits.

// File: rtl/qspi_master.sv
module qspi_master #(
  parameter int DIVW = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        irq,
  output logic        sck,
  output logic        so,
  input  logic        si,
  output logic [3:0]  cs
);
  localparam int DEPTH = 16;
  localparam int PW = $clog2(DEPTH) + 1;

  logic pwr, rx_en, duplex, cpol, cpha, lsb;
  logic [3:0] flen, cs_pol;
  logic [1:0] cs_hold, csel;
  logic [DIVW-1:0] div, hcnt;
  logic [17:0] txm [DEPTH];
  logic [15:0] rxm [DEPTH];
  logic [PW-1:0] twp, trp, rwp, rrp, left;
  logic busy, sck_lv, so_q, irq_q;
  logic [5:0] ecnt;
  logic [15:0] txs, rxs;

  wire [4:0] len = (flen == 4'd0) ? 5'd16 : {1'b0, flen};
  wire [3:0] top_i = flen - 4'd1;
  wire [5:0] last_e = {len, 1'b0};
  wire tx_full  = (twp - trp) == PW'(DEPTH);
  wire tx_empty = twp == trp;
  wire rx_full  = (rwp - rrp) == PW'(DEPTH);
  wire rx_empty = rwp == rrp;

  wire push  = bus_wr && bus_addr == 3'd5 && !tx_full;
  wire pop   = bus_rd && bus_addr == 3'd6 && !rx_empty;
  wire clr   = bus_wr && bus_addr == 3'd7 && bus_wdata[0];
  wire start = !busy && pwr && left != '0 && !tx_empty;
  wire tick  = busy && hcnt == div;
  wire fin   = tick && ecnt == last_e;
  wire lead  = !sck_lv;
  wire smp   = tick && !fin && (cpha ? !lead : lead);
  wire drv   = tick && !fin && (cpha ? lead : (!lead && ecnt != last_e - 6'd1));
  wire keep  = fin && rx_en && !rx_full;

  wire [17:0] head = txm[trp[3:0]];
  wire [15:0] tsrc = start ? head[15:0] : txs;
  wire        tbit = lsb ? tsrc[0] : tsrc[top_i];
  wire [15:0] tshf = lsb ? (tsrc >> 1) : (tsrc << 1);
  wire [15:0] rins = lsb ? ((rxs >> 1) | ({15'd0, si} << top_i)) : {rxs[14:0], si};

  always_ff @(posedge clk) begin
    if (push) txm[twp[3:0]] <= {cs_hold, bus_wdata};
    if (keep) rxm[rwp[3:0]] <= rxs;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {pwr, rx_en, duplex, cpol, cpha, lsb} <= '0;
      flen <= '0; cs_pol <= '0; cs_hold <= '0; csel <= '0;
      div <= '0; hcnt <= '0; ecnt <= '0;
      twp <= '0; trp <= '0; rwp <= '0; rrp <= '0; left <= '0;
      busy <= 1'b0; sck_lv <= 1'b0; so_q <= 1'b0; irq_q <= 1'b0;
      txs <= '0; rxs <= '0;
    end else begin
      irq_q <= 1'b0;
      if (bus_wr) begin
        case (bus_addr)
          3'd0: {flen, lsb, cpha, cpol, duplex, rx_en, pwr} <= {bus_wdata[11:8], bus_wdata[5:0]};
          3'd1: div <= bus_wdata[DIVW-1:0];
          3'd2: left <= (bus_wdata[3:0] == 4'd0) ? PW'(DEPTH) : PW'(bus_wdata[3:0]);
          3'd3: cs_pol <= bus_wdata[3:0];
          3'd4: cs_hold <= bus_wdata[1:0];
          default: ;
        endcase
      end
      if (push) twp <= twp + 1'b1;
      if (pop) rrp <= rrp + 1'b1;
      if (start) begin
        busy <= 1'b1; hcnt <= '0; ecnt <= '0; sck_lv <= 1'b0; rxs <= '0;
        csel <= head[17:16];
        trp <= trp + 1'b1;
        txs <= cpha ? head[15:0] : tshf;
        if (!cpha && duplex) so_q <= tbit;
      end else if (busy) begin
        hcnt <= tick ? '0 : hcnt + 1'b1;
        if (tick && !fin) begin
          sck_lv <= ~sck_lv;
          ecnt <= ecnt + 6'd1;
        end
        if (smp) rxs <= rins;
        if (drv) begin
          txs <= tshf;
          if (duplex) so_q <= tbit;
        end
        if (fin) begin
          busy <= 1'b0;
          left <= left - 1'b1;
          irq_q <= left == PW'(1);
          if (keep) rwp <= rwp + 1'b1;
        end
      end
      if (clr) begin
        twp <= '0; trp <= '0; rwp <= '0; rrp <= '0;
        busy <= 1'b0; sck_lv <= 1'b0;
      end
    end
  end

  always_comb
    for (int i = 0; i < 4; i++)
      cs[i] = (busy && csel == 2'(i)) ? cs_pol[i] : ~cs_pol[i];

  assign sck = sck_lv ^ cpol;
  assign so  = so_q;
  assign irq = irq_q;
  assign bus_rdata = (bus_addr == 3'd6) ? (rx_empty ? 16'd0 : rxm[rrp[3:0]]) :
                     (bus_addr == 3'd7) ? {12'd0, busy, rx_empty, tx_empty, tx_full} : 16'd0;

  // R2
  tx_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (twp - trp) <= PW'(DEPTH));
  // R9
  sck_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && $past(!busy) && $stable(cpol) |-> $stable(sck));
  // R6
  so_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !duplex && $past(!duplex) |-> $stable(so));
  // R7
  cs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~(cs ^ cs_pol)));
  // R3
  irq_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> left == '0 && !busy);
  // R7
  cs_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(csel));
endmodule

// File: tb/tb_qspi_master.sv
module tb_qspi_master;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic irq, sck, so, si_r = 1'b0;
  logic [3:0] cs;

  qspi_master dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .sck(sck), .so(so), .si(si_r), .cs(cs));

  always #2 clk = ~clk;

  int tests = 0, fails = 0;
  bit mon_en = 0, in_frame = 0;
  bit cfg_cpol, cfg_cpha, cfg_lsb, cfg_dup;
  int cfg_len = 8, cfg_div = 0;
  logic [3:0] cfg_pol = '0, act;
  logic [15:0] sw [16], cap [16], txd [16], capw;
  int cs_seen [16], csc [16];
  int sf = 0, k = 0, c = 0, irq_cnt = 0, hc = 0;
  bit multi_bad, per_bad, so_moved, irq_long, prev_irq;
  logic psck, pcs_any;
  logic [3:0] pcs;

  task automatic chk(input string tag, input int act_v, input int exp_v);
    tests++;
    if (act_v != exp_v) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act_v, exp_v);
    end
  endtask

  function automatic bit sbit(input logic [15:0] w, input int kk);
    if (kk >= cfg_len) return 1'b0;
    return cfg_lsb ? w[kk] : w[cfg_len-1-kk];
  endfunction

  always @(cs) if (mon_en) begin
    act = ~(cs ^ cfg_pol);
    if ($countones(act) > 1) multi_bad = 1;
    if (act != 0 && !in_frame && sf < 16) begin
      in_frame = 1;
      for (int i = 0; i < 4; i++) if (act[i]) cs_seen[sf] = i;
      k = 0; c = 0; capw = '0;
      if (!cfg_cpha) si_r = sbit(sw[sf], 0);
    end else if (act == 0 && in_frame) begin
      in_frame = 0;
      cap[sf] = capw;
      sf++;
    end
  end

  always @(sck) if (mon_en && in_frame) begin
    bit ld, sm;
    ld = (sck != cfg_cpol);
    sm = cfg_cpha ? !ld : ld;
    if (sm) begin
      if (cfg_lsb) capw[c] = so; else capw = {capw[14:0], so};
      c++;
    end
    if (!cfg_cpha && !ld) begin k++; si_r = sbit(sw[sf], k); end
    if (cfg_cpha && ld) begin si_r = sbit(sw[sf], k); k++; end
  end

  always @(so) if (mon_en && !cfg_dup) so_moved = 1;

  always @(negedge clk) begin
    if (sck !== psck || cs !== pcs) begin
      if (mon_en && in_frame && sck !== psck && hc != cfg_div + 1) per_bad = 1;
      hc = 1;
    end else hc++;
    psck = sck; pcs = cs;
    if (irq) irq_cnt++;
    if (irq && prev_irq) irq_long = 1;
    prev_irq = irq;
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_addr = 3'(a); bus_wdata = 16'(d); bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    bus_addr = 3'(a); bus_rd = 1'b1;
    #1 d = int'(bus_rdata);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic run_case(input bit pc, input bit ph, input bit lf, input bit dup,
                          input bit rxen, input int len, input int dv, input int n,
                          input int nstall, input bit prefill, input logic [3:0] pol);
    int mask, d, st, bad_cs, bad_tx, bad_rx;
    mon_en = 0;
    cfg_cpol = pc; cfg_cpha = ph; cfg_lsb = lf; cfg_dup = dup;
    cfg_len = len; cfg_div = dv; cfg_pol = pol;
    mask = (len == 16) ? 32'hFFFF : ((1 << len) - 1);
    for (int i = 0; i < n; i++) begin
      txd[i] = 16'($urandom & mask);
      sw[i]  = 16'($urandom & mask);
      csc[i] = int'($urandom % 4);
    end
    wr(7, 1); wr(1, dv); wr(3, pol);
    wr(0, {4'd0, 4'(len), 2'b00, lf, ph, pc, dup, rxen, !prefill});
    wr(2, n & 15);
    repeat (3) @(negedge clk);
    sf = 0; irq_cnt = 0; in_frame = 0;
    per_bad = 0; multi_bad = 0; so_moved = 0; irq_long = 0;
    if (prefill) begin
      for (int i = 0; i < n; i++) begin wr(4, csc[i]); wr(5, txd[i]); end
      wr(4, 0); wr(5, 16'h5A5A);
      rd(7, st);
      chk("R2 queue full flag", st & 1, 1);
      mon_en = 1;
      wr(0, {4'd0, 4'(len), 2'b00, lf, ph, pc, dup, rxen, 1'b1});
    end else begin
      mon_en = 1;
      for (int i = 0; i < n; i++) begin
        if (i == nstall) begin
          for (int t = 0; t < 20000 && sf < nstall; t++) @(negedge clk);
          repeat (4 * (dv + 1) + 6) @(negedge clk);
          chk("R9 sck idle on empty queue", int'(sck), int'(pc));
          chk("R9 no early irq", irq_cnt, 0);
          chk("R9 frames so far", sf, nstall);
        end
        wr(4, csc[i]); wr(5, txd[i]);
      end
    end
    for (int t = 0; t < 40000 && irq_cnt == 0; t++) @(negedge clk);
    repeat (4 * (dv + 1) + 6) @(negedge clk);
    mon_en = 0;
    chk("R3 irq count", irq_cnt, 1);
    chk("R3 irq single cycle", int'(irq_long), 0);
    chk("R3 frames run", sf, n);
    chk("R4 half period", int'(per_bad), 0);
    chk("R7 one line active", int'(multi_bad), 0);
    bad_cs = 0; bad_tx = 0;
    for (int i = 0; i < n; i++) begin
      if (cs_seen[i] != csc[i]) bad_cs++;
      if (dup && cap[i] != txd[i]) bad_tx++;
    end
    chk("R7 line per entry", bad_cs, 0);
    if (dup) chk("R6 SO words", bad_tx, 0);
    else chk("R6 SO held", int'(so_moved), 0);
    bad_rx = 0;
    if (rxen) begin
      for (int i = 0; i < n; i++) begin
        rd(6, d);
        if (d != int'(sw[i])) bad_rx++;
      end
      chk("R5 received words", bad_rx, 0);
    end
    rd(7, st);
    chk("R8 rx empty after drain", (st >> 2) & 1, 1);
    if (prefill) chk("R2 extra push dropped", (st >> 1) & 1, 1);
  endtask

  initial begin
    #(4 * 190000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int st;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 cs idle", int'(cs), 15);
    chk("R1 sck", int'(sck), 0);
    chk("R1 so", int'(so), 0);
    chk("R1 irq", int'(irq), 0);
    rd(7, st);
    chk("R1 status", st, 6);
    // R10
    for (int i = 0; i < 5; i++) begin wr(4, i); wr(5, i); end
    wr(7, 1);
    rd(7, st);
    chk("R10 pointer clear", st, 6);
    run_case(0, 0, 0, 1, 1, 8, 1, 16, 99, 1, 4'h0);
    run_case(1, 1, 0, 1, 1, 12, 2, 8, 3, 0, 4'h5);
    run_case(0, 1, 0, 0, 1, 8, 0, 6, 99, 0, 4'h0);
    run_case(1, 0, 1, 1, 0, 10, 1, 5, 99, 0, 4'hF);
    run_case(0, 0, 1, 1, 1, 16, 3, 4, 99, 0, 4'h3);
    run_case(1, 1, 1, 1, 1, 1, 0, 7, 99, 0, 4'h9);
    for (int r = 0; r < 18; r++) begin
      int n;
      n = int'($urandom % 10) + 1;
      run_case(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
               ($urandom % 4) != 0, int'($urandom % 16) + 1, int'($urandom % 4),
               n, (($urandom % 3) == 0) ? int'($urandom % n) : 99, 0, 4'($urandom));
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule